// File: doc/BRIEF.md
# Memory Signature Checker

This block folds a stream of 16-bit memory words into a 16-bit pseudo-random signature and compares the result with a signature that a target device reports for the same address range. It serves two jobs. In data mode it confirms that a region holds the data that was programmed. In erase-check mode it confirms that a region reads back as all ones.

A run begins with a start strobe that carries the region's start address. The signature register is seeded from that address. Each valid word then advances the register by one step, at one word per clock and with no backpressure. A final strobe carries the target's signature. One cycle later the block raises a single-cycle done pulse and a match flag. The match flag keeps its value until the next start. The link that fetches the target's signature lies outside this block.

Top module: `psa_sig_check`

## Requirements
- R1: After reset, sig_o is 0x0000, match_o is 0 and done_o is 0.
- R2: A start strobe loads sig_o with start_addr_i minus 2, taken modulo 2^16, in the next cycle. It re-seeds even in the middle of a run, and in the same cycle it overrides any word or final strobe.
- R3: For an accepted word, when bit 15 of the register is 1, the register is XORed with the polynomial 0x0805, shifted left by one, and then has bit 0 set to 1.
- R4: For an accepted word, when bit 15 of the register is 0, the register is only shifted left by one. Each accepted word takes one clock and shows on sig_o in the next cycle.
- R5: After the step in R3 or R4, the register is XORed with word_i. When erase_i was 1 at the start strobe, the register is XORed with 0xFFFF instead and word_i has no effect.
- R6: A final strobe after a start gives a done_o pulse of exactly one cycle in the next cycle. In that same cycle match_o is 1 only if sig_i equals the computed signature in all 16 bits.
- R7: Word and final strobes are ignored before the first start and after a comparison, until the next start. While they are ignored, sig_o does not change and done_o stays 0.
- R8: match_o holds its value until the next start strobe. A start strobe clears match_o to 0 in the next cycle.
- R9: A word strobe in the same cycle as a final strobe is not folded in. The comparison uses the signature as it stood before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a run and seeds the signature register |
| start_addr_i | input | 16 | Start address of the region, used for the seed |
| erase_i | input | 1 | Erase-check mode, sampled at start |
| word_vld_i | input | 1 | word_i holds a word to fold in |
| word_i | input | 16 | Memory data word |
| sig_vld_i | input | 1 | Final strobe; sig_i holds the target's signature |
| sig_i | input | 16 | Signature reported by the target |
| sig_o | output | 16 | Running computed signature |
| match_o | output | 1 | Comparison result, held until the next start |
| done_o | output | 1 | One-cycle pulse when a comparison completes |

## Verification
The bench aims at the seed wrap-around, where a start address below 2 must wrap to 0xFFFE or 0xFFFF. A design that saturates or drops the borrow would give the wrong signature for every word that follows. It also tests erase mode with changing data on word_i: a design that still folds in real data would report a mismatch on a clean erase. A single flipped bit in the target's signature must read as a mismatch, which catches a comparison that checks only part of the word. The bench also tries strobes before the first start, after a comparison, and together with a final strobe, and it restarts in the middle of a run. A design that leaks any of these into the register, or sends a stray done pulse, is flagged by the scoreboard.

// File: rtl/psa_sig_check.sv
module psa_sig_check #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = 16'h0805
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] start_addr_i,
  input  logic         erase_i,
  input  logic         word_vld_i,
  input  logic [W-1:0] word_i,
  input  logic         sig_vld_i,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] sig_o,
  output logic         match_o,
  output logic         done_o
);

  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] TWO  = W'(2);

  logic [W-1:0] sig_q;
  logic         armed_q;
  logic         erase_q;
  logic         match_q;
  logic         done_q;

  function automatic logic [W-1:0] fold(input logic [W-1:0] s, input logic [W-1:0] d);
    logic [W-1:0] t;
    if (s[W-1]) begin
      t = (s ^ POLY) << 1;
      t[0] = 1'b1;
    end else begin
      t = s << 1;
    end
    return t ^ d;
  endfunction

  wire [W-1:0] mixin   = erase_q ? ONES : word_i;
  wire         take_wd = armed_q && word_vld_i && !sig_vld_i;
  wire         take_sg = armed_q && sig_vld_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q   <= '0;
      armed_q <= 1'b0;
      erase_q <= 1'b0;
      match_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (start_i) begin
      sig_q   <= start_addr_i - TWO;
      armed_q <= 1'b1;
      erase_q <= erase_i;
      match_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= take_sg;
      if (take_sg) begin
        match_q <= (sig_i == sig_q);
        armed_q <= 1'b0;
      end else if (take_wd) begin
        sig_q <= fold(sig_q, mixin);
      end
    end
  end

  assign sig_o   = sig_q;
  assign match_o = match_q;
  assign done_o  = done_q;

endmodule

module psa_sig_check_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic [W-1:0] start_addr_i,
  input logic         word_vld_i,
  input logic         sig_vld_i,
  input logic [W-1:0] sig_i,
  input logic [W-1:0] sig_o,
  input logic         match_o,
  input logic         done_o,
  input logic         armed
);

  a_r2_seed: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> sig_o == $past(start_addr_i) - W'(2));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_compare: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && sig_vld_i && !start_i) |=> (done_o && (match_o == ($past(sig_i) == $past(sig_o)))));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !start_i) |=> ($stable(sig_o) && !done_o));

  a_r8_match_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !(armed && sig_vld_i)) |=> $stable(match_o));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !match_o);

  a_r9_no_fold: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && sig_vld_i && word_vld_i && !start_i) |=> $stable(sig_o));

endmodule

bind psa_sig_check psa_sig_check_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
  .word_vld_i(word_vld_i), .sig_vld_i(sig_vld_i), .sig_i(sig_i),
  .sig_o(sig_o), .match_o(match_o), .done_o(done_o), .armed(armed_q)
);

// File: tb/psa_sig_check_tb.sv
module psa_sig_check_tb;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        start_i = 0;
  logic [15:0] start_addr_i = 0;
  logic        erase_i = 0;
  logic        word_vld_i = 0;
  logic [15:0] word_i = 0;
  logic        sig_vld_i = 0;
  logic [15:0] sig_i = 0;
  logic [15:0] sig_o;
  logic        match_o;
  logic        done_o;

  always #2.5 clk = ~clk;

  psa_sig_check u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .erase_i(erase_i), .word_vld_i(word_vld_i), .word_i(word_i),
    .sig_vld_i(sig_vld_i), .sig_i(sig_i), .sig_o(sig_o),
    .match_o(match_o), .done_o(done_o)
  );

  typedef struct { logic [15:0] sig; logic match; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;

  function automatic logic [15:0] model_step(logic [15:0] s, logic [15:0] d);
    logic [15:0] t;
    if (s[15]) t = ((s ^ 16'h0805) << 1) | 16'h0001;
    else       t = s << 1;
    return t ^ d;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    start_i = 0; word_vld_i = 0; sig_vld_i = 0;
  endtask

  task automatic do_start(logic [15:0] addr, bit er);
    @(negedge clk);
    idle(); start_i = 1; start_addr_i = addr; erase_i = er;
    @(negedge clk);
    idle();
  endtask

  // Runs a full block; bad flips one bit of the reported signature;
  // overlap raises a junk word with the final strobe (R9).
  task automatic run_block(logic [15:0] addr, bit er, int n, logic [15:0] base,
                           bit bad, bit overlap, string tag);
    logic [15:0] m;
    exp_t e;
    m = addr - 16'd2;
    do_start(addr, er);
    for (int i = 0; i < n; i++) begin
      logic [15:0] w;
      w = base ^ 16'(i * 16'h3B1D) ^ 16'(i << 9);
      word_vld_i = 1; word_i = w;
      m = model_step(m, er ? 16'hFFFF : w);
      @(negedge clk);
    end
    idle();
    e.sig = m; e.match = !bad; e.tag = tag;
    q.push_back(e);
    sig_vld_i = 1; sig_i = bad ? (m ^ 16'h0100) : m;
    if (overlap) begin word_vld_i = 1; word_i = 16'hDEAD; end
    @(negedge clk);
    idle();
  endtask

  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (q.size() == 0) begin
        check(0, "R7 unexpected done", 32'(done_o), 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(sig_o == e.sig, {"R6 signature ", e.tag}, 32'(sig_o), 32'(e.sig));
        check(match_o == e.match, {"R6 match ", e.tag}, 32'(match_o), 32'(e.match));
      end
    end
  end

  initial begin
    #400000;
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sig_o == 16'h0000, "R1 sig", 32'(sig_o), 0);
    check(match_o == 1'b0, "R1 match", 32'(match_o), 0);
    check(done_o == 1'b0, "R1 done", 32'(done_o), 0);
    rst_n = 1;
    @(negedge clk);

    // R7: strobes before any start
    word_vld_i = 1; word_i = 16'h1234;
    @(negedge clk);
    sig_vld_i = 1; sig_i = 16'h0000;
    @(negedge clk);
    idle();
    @(negedge clk);
    check(sig_o == 16'h0000, "R7 pre-start word", 32'(sig_o), 0);

    // R2 seed and R4/R5 known answer: seed 0, word 0x1234 -> 0x1234
    do_start(16'h0002, 0);
    check(sig_o == 16'h0000, "R2 seed", 32'(sig_o), 0);
    word_vld_i = 1; word_i = 16'h1234;
    @(negedge clk);
    idle();
    check(sig_o == 16'h1234, "R4 shift-only step", 32'(sig_o), 32'h1234);

    // R2 wrap and R3/R5 erase known answer: seed 0xFFFE -> 0x1008
    do_start(16'h0000, 1);
    check(sig_o == 16'hFFFE, "R2 seed wrap", 32'(sig_o), 32'hFFFE);
    word_vld_i = 1; word_i = 16'h0000;
    @(negedge clk);
    idle();
    check(sig_o == 16'h1008, "R3 feedback step erase", 32'(sig_o), 32'h1008);

    // R8: start clears a set match
    run_block(16'h0200, 0, 8, 16'hA5A5, 0, 0, "data pass");
    @(negedge clk);
    check(match_o == 1'b1, "R8 held after pass", 32'(match_o), 1);
    do_start(16'h0300, 0);
    check(match_o == 1'b0, "R8 cleared by start", 32'(match_o), 0);

    run_block(16'hF000, 0, 20, 16'h8001, 1, 0, "data mismatch");
    run_block(16'hC000, 1, 16, 16'h7777, 0, 0, "erase pass");
    run_block(16'h0001, 1, 5, 16'h0F0F, 1, 0, "erase mismatch wrap");
    run_block(16'h1100, 0, 12, 16'h5A5A, 0, 1, "R9 overlap word");

    // R7 + R8: after compare, strobes ignored and result held
    run_block(16'h2000, 0, 4, 16'hFFFF, 0, 0, "before hold");
    @(negedge clk);
    begin
      logic [15:0] s;
      s = sig_o;
      word_vld_i = 1; word_i = 16'h4321;
      @(negedge clk);
      idle(); sig_vld_i = 1; sig_i = s ^ 16'h1;
      @(negedge clk);
      idle();
      repeat (3) @(negedge clk);
      check(sig_o == s, "R7 post-compare word", 32'(sig_o), 32'(s));
      check(match_o == 1'b1, "R8 held after ignored strobe", 32'(match_o), 1);
    end

    // R2: restart mid-stream
    do_start(16'h4444, 0);
    for (int i = 0; i < 3; i++) begin
      word_vld_i = 1; word_i = 16'(i + 7);
      @(negedge clk);
    end
    idle();
    run_block(16'h8888, 0, 6, 16'h1357, 0, 0, "R2 restart");

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R6 all results seen", 32'(q.size()), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule